// File: doc/BRIEF.md
# Machine Check Collector

This block gathers hardware fault indications and turns them into machine check interrupts for a group of processors. Each processor reports the faults seen on its own accesses: internal faults, bus time-outs, address or data parity faults, uncorrectable ECC faults and accesses to unmapped addresses. A single external machine-check pin is shared by all of them. A fault on a processor's own access interrupts only that processor. The external pin interrupts every enabled processor in the same cycle, so that their handlers can agree on which one collects the fault data.

When an interrupt is taken, the block records a one-hot cause code for that processor and the address of the instruction that would have run next. The interrupt stays up until the processor pulses its clear strobe. A further fault that arrives while it is still pending sets a sticky overflow flag.

Faults that software can recover from take a separate path: one maskable interrupt line. Faults that cannot be survived raise a checkstop and capture a residual word. Only a power-on reset wipes that word, so software can read it after a normal reboot.

Top module: `mchk_collector`

## Requirements
- R1: A processor whose `mc_en` bit is 0 does not get an interrupt, a cause code or an overflow from any fault.
- R2: `mc_src` for a processor is one-hot with this bit order: 0 internal, 1 bus time-out, 2 address parity, 3 data parity, 4 uncorrectable ECC, 5 invalid address, 6 external pin. When several causes arrive in the same cycle, the lowest-numbered one is recorded. The code appears one clock after the fault is sampled.
- R3: `mc_pc` holds the processor's `next_pc` slice as it was at the capture edge. It does not change while the interrupt is pending.
- R4: A high `ext_mc` raises `mc_irq` on every enabled processor on the same clock edge.
- R5: A fault on a processor's own access interrupts only that processor.
- R6: `mc_irq` stays high until `mc_clr` is pulsed. A clear with no new fault drops `mc_irq` and `mc_ovf` one clock later. A clear that arrives with a new fault captures the new fault in place of the old one.
- R7: A fault that hits an enabled processor whose interrupt is already pending, with no clear in that cycle, sets `mc_ovf`. The recorded cause and address do not change.
- R8: `rec_err` sets a pending flag. `rec_irq` is that flag AND NOT `rec_mask`. `rec_clr` clears the flag, and a new `rec_err` in the same cycle wins over the clear. Recoverable faults never raise `mc_irq`.
- R9: `fatal_err` sets `checkstop` one clock later. `checkstop` stays high until either reset, and a fatal fault raises no `mc_irq`.
- R10: The first `fatal_err` copies `fatal_info` into `resid_info` and sets `resid_vld`. Later fatal faults and `rst_n` leave both unchanged. Only `por_n` clears them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; does not touch the residual word |
| por_n | input | 1 | Synchronous active-low power-on reset; clears everything |
| mc_en | input | NCPU | Per-processor machine check enable |
| err_internal | input | NCPU | Internal processor fault, per processor |
| err_bus_tmo | input | NCPU | Bus time-out on that processor's access |
| err_addr_par | input | NCPU | Address parity fault on that processor's access |
| err_data_par | input | NCPU | Data parity fault on that processor's access |
| err_ecc_ue | input | NCPU | Uncorrectable memory or cache ECC on that processor's access |
| err_bad_addr | input | NCPU | Access to an unmapped address by that processor |
| ext_mc | input | 1 | External machine-check pin, sent to every processor |
| next_pc | input | NCPU*AW | Next-instruction address of each processor |
| mc_clr | input | NCPU | Per-processor clear strobe |
| mc_irq | output | NCPU | Per-processor machine check interrupt |
| mc_src | output | NCPU*7 | Per-processor one-hot cause code |
| mc_pc | output | NCPU*AW | Per-processor saved next-instruction address |
| mc_ovf | output | NCPU | Per-processor sticky overflow flag |
| rec_err | input | 1 | Recoverable fault indication |
| rec_mask | input | 1 | Mask for the recoverable interrupt |
| rec_clr | input | 1 | Clear for the recoverable pending flag |
| rec_irq | output | 1 | Recoverable-fault interrupt |
| fatal_err | input | 1 | Unrecoverable fault indication |
| fatal_info | input | IW | Fault data to keep in the residual word |
| checkstop | output | 1 | Checkstop request |
| resid_vld | output | 1 | Residual word holds a captured fault |
| resid_info | output | IW | Residual fault data |

## Verification
Each single local cause is driven on each processor twice: once with that processor enabled and once with only that processor disabled. This separates the routing to the right processor, the enable gating, the cause bit position and the address capture. All 63 combinations of the six local causes are driven together on one processor, which exposes any flaw in the lowest-bit-wins choice. The external pin is swept over all 16 enable patterns, and once together with a local cause, to tell broadcast apart from local routing. Directed sequences cover overflow, holding until clear, and a clear that coincides with a new fault. Further sequences cover mask behaviour on the recoverable path and the different effects of the two resets on the checkstop and the residual word.

// File: rtl/mchk_collector.sv
module mchk_collector #(
  parameter int NCPU = 4,
  parameter int AW   = 32,
  parameter int IW   = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              por_n,
  input  logic [NCPU-1:0]   mc_en,
  input  logic [NCPU-1:0]   err_internal,
  input  logic [NCPU-1:0]   err_bus_tmo,
  input  logic [NCPU-1:0]   err_addr_par,
  input  logic [NCPU-1:0]   err_data_par,
  input  logic [NCPU-1:0]   err_ecc_ue,
  input  logic [NCPU-1:0]   err_bad_addr,
  input  logic              ext_mc,
  input  logic [NCPU*AW-1:0] next_pc,
  input  logic [NCPU-1:0]   mc_clr,
  output logic [NCPU-1:0]   mc_irq,
  output logic [NCPU*7-1:0] mc_src,
  output logic [NCPU*AW-1:0] mc_pc,
  output logic [NCPU-1:0]   mc_ovf,
  input  logic              rec_err,
  input  logic              rec_mask,
  input  logic              rec_clr,
  output logic              rec_irq,
  input  logic              fatal_err,
  input  logic [IW-1:0]     fatal_info,
  output logic              checkstop,
  output logic              resid_vld,
  output logic [IW-1:0]     resid_info
);
  localparam int NSRC = 7;

  logic any_rst;
  assign any_rst = !por_n || !rst_n;

  for (genvar g = 0; g < NCPU; g++) begin : g_cpu
    logic [NSRC-1:0] raw, first;
    logic            hit;
    assign raw   = {ext_mc, err_bad_addr[g], err_ecc_ue[g], err_data_par[g],
                    err_addr_par[g], err_bus_tmo[g], err_internal[g]};
    assign first = raw & (~raw + NSRC'(1));
    assign hit   = mc_en[g] && (|raw);

    always_ff @(posedge clk) begin
      if (any_rst) begin
        mc_irq[g]               <= 1'b0;
        mc_ovf[g]               <= 1'b0;
        mc_src[g*NSRC +: NSRC]  <= '0;
        mc_pc[g*AW +: AW]       <= '0;
      end else if (mc_clr[g] || !mc_irq[g]) begin
        mc_irq[g] <= hit;
        mc_ovf[g] <= 1'b0;
        mc_src[g*NSRC +: NSRC] <= hit ? first : '0;
        if (hit) mc_pc[g*AW +: AW] <= next_pc[g*AW +: AW];
      end else if (hit) begin
        mc_ovf[g] <= 1'b1;
      end
    end
  end

  logic rec_pend;
  always_ff @(posedge clk) begin
    if (any_rst) rec_pend <= 1'b0;
    else         rec_pend <= rec_err || (rec_pend && !rec_clr);
  end
  assign rec_irq = rec_pend && !rec_mask;

  always_ff @(posedge clk) begin
    if (any_rst) checkstop <= 1'b0;
    else         checkstop <= checkstop || fatal_err;
  end

  always_ff @(posedge clk) begin
    if (!por_n) begin
      resid_vld  <= 1'b0;
      resid_info <= '0;
    end else if (fatal_err && !resid_vld) begin
      resid_vld  <= 1'b1;
      resid_info <= fatal_info;
    end
  end
endmodule

// File: rtl/mchk_collector_chk.sv
module mchk_collector_chk #(
  parameter int NCPU = 4,
  parameter int AW   = 32,
  parameter int IW   = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              por_n,
  input logic [NCPU-1:0]   mc_en,
  input logic              ext_mc,
  input logic [NCPU-1:0]   mc_clr,
  input logic [NCPU-1:0]   mc_irq,
  input logic [NCPU*7-1:0] mc_src,
  input logic [NCPU*AW-1:0] mc_pc,
  input logic [NCPU-1:0]   mc_ovf,
  input logic              rec_mask,
  input logic              rec_irq,
  input logic              checkstop,
  input logic              resid_vld,
  input logic [IW-1:0]     resid_info
);
  localparam int NSRC = 7;

  logic up_q;
  always_ff @(posedge clk) up_q <= rst_n && por_n;

  for (genvar i = 0; i < NCPU; i++) begin : g_chk
    AST_NO_MC_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
      (up_q && !mc_en[i] && !mc_irq[i]) |=> !mc_irq[i]); // R1
    AST_SRC_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
      mc_irq[i] |-> ($countones(mc_src[i*NSRC +: NSRC]) == 1)); // R2
    AST_PC_HELD: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
      (up_q && mc_irq[i] && !mc_clr[i]) |=> $stable(mc_pc[i*AW +: AW])); // R3
    AST_EXT_ALL: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
      (up_q && ext_mc && mc_en[i]) |=> mc_irq[i]); // R4
    AST_MC_HELD: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
      (up_q && mc_irq[i] && !mc_clr[i]) |=> mc_irq[i]); // R6
    AST_OVF_NEEDS_PEND: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
      mc_ovf[i] |-> mc_irq[i]); // R7
  end

  AST_REC_MASKED: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    rec_mask |-> !rec_irq); // R8
  AST_CHECKSTOP_HOLD: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    (up_q && checkstop) |=> checkstop); // R9
  AST_RESID_FROZEN: assert property (@(posedge clk) disable iff (!por_n)
    resid_vld |=> (resid_vld && $stable(resid_info))); // R10
endmodule

bind mchk_collector mchk_collector_chk #(.NCPU(NCPU), .AW(AW), .IW(IW)) u_chk (
  .clk(clk), .rst_n(rst_n), .por_n(por_n), .mc_en(mc_en), .ext_mc(ext_mc),
  .mc_clr(mc_clr), .mc_irq(mc_irq), .mc_src(mc_src), .mc_pc(mc_pc),
  .mc_ovf(mc_ovf), .rec_mask(rec_mask), .rec_irq(rec_irq),
  .checkstop(checkstop), .resid_vld(resid_vld), .resid_info(resid_info)
);

// File: tb/mchk_collector_tb_top.sv
`timescale 1ns/1ps
module mchk_collector_tb_top;
  localparam int N = 4, AW = 32, IW = 32;

  logic clk = 0, rst_n = 0, por_n = 0;
  logic [N-1:0] mc_en = '0, e_int = '0, e_tmo = '0, e_ap = '0, e_dp = '0, e_ecc = '0, e_bad = '0, mc_clr = '0;
  logic ext_mc = 0, rec_err = 0, rec_mask = 0, rec_clr = 0, fatal_err = 0;
  logic [N*AW-1:0] next_pc = '0;
  logic [IW-1:0] fatal_info = '0;
  logic [N-1:0] mc_irq, mc_ovf;
  logic [N*7-1:0] mc_src;
  logic [N*AW-1:0] mc_pc;
  logic rec_irq, checkstop, resid_vld;
  logic [IW-1:0] resid_info;

  int nchk = 0, nfail = 0, cyc = 0;
  bit done = 0;

  always #10 clk = ~clk;

  mchk_collector #(.NCPU(N), .AW(AW), .IW(IW)) dut_i (
    .clk(clk), .rst_n(rst_n), .por_n(por_n), .mc_en(mc_en),
    .err_internal(e_int), .err_bus_tmo(e_tmo), .err_addr_par(e_ap),
    .err_data_par(e_dp), .err_ecc_ue(e_ecc), .err_bad_addr(e_bad),
    .ext_mc(ext_mc), .next_pc(next_pc), .mc_clr(mc_clr), .mc_irq(mc_irq),
    .mc_src(mc_src), .mc_pc(mc_pc), .mc_ovf(mc_ovf), .rec_err(rec_err),
    .rec_mask(rec_mask), .rec_clr(rec_clr), .rec_irq(rec_irq),
    .fatal_err(fatal_err), .fatal_info(fatal_info), .checkstop(checkstop),
    .resid_vld(resid_vld), .resid_info(resid_info));

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      nfail++;
      $display("FAIL watchdog: actual=%0d cycles expected<150000", cyc);
      summary();
      $finish;
    end
  end

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic put_err(input int c, input int s, input logic v);
    case (s)
      0: e_int[c] = v;
      1: e_tmo[c] = v;
      2: e_ap[c]  = v;
      3: e_dp[c]  = v;
      4: e_ecc[c] = v;
      5: e_bad[c] = v;
      default: ext_mc = v;
    endcase
  endtask

  task automatic clear_all();
    mc_clr = '1; tick(); mc_clr = '0;
    chk("R6 clear drops irq", mc_irq, 0);
  endtask

  initial begin
    repeat (3) tick();
    por_n = 1; rst_n = 1;
    chk("R6 reset irq", mc_irq, 0);
    chk("R9 reset checkstop", checkstop, 0);
    chk("R10 reset resid_vld", resid_vld, 0);
    chk("R8 reset rec_irq", rec_irq, 0);

    // R1 R3 R5: every local cause, every processor, enabled and disabled
    for (int c = 0; c < N; c++)
      for (int s = 0; s < 6; s++)
        for (int e = 0; e < 2; e++) begin
          mc_en = e ? '1 : ~(N'(1) << c);
          next_pc[c*AW +: AW] = 32'hA000_0000 + c*256 + s*2 + e;
          put_err(c, s, 1'b1); tick(); put_err(c, s, 1'b0);
          chk("R5/R1 irq routing", mc_irq, e ? (64'd1 << c) : 0);
          chk("R2 cause code", mc_src[c*7 +: 7], e ? (64'd1 << s) : 0);
          chk("R1 no overflow", mc_ovf, 0);
          if (e) chk("R3 saved address", mc_pc[c*AW +: AW], 32'hA000_0000 + c*256 + s*2 + 1);
          clear_all();
        end

    // R2: all local cause combinations on processor 2
    mc_en = '1;
    for (int a = 1; a < 64; a++) begin
      for (int s = 0; s < 6; s++) put_err(2, s, a[s]);
      tick();
      for (int s = 0; s < 6; s++) put_err(2, s, 1'b0);
      chk("R2 lowest cause wins", mc_src[2*7 +: 7], a & (-a));
      clear_all();
    end

    // R4: external pin over every enable pattern
    for (int p = 0; p < 16; p++) begin
      mc_en = p[N-1:0];
      ext_mc = 1; tick(); ext_mc = 0;
      chk("R4 broadcast", mc_irq, p);
      for (int c = 0; c < N; c++)
        if (p[c]) chk("R4 ext cause", mc_src[c*7 +: 7], 64);
      clear_all();
    end
    mc_en = '1;
    ext_mc = 1; e_int[0] = 1; tick(); ext_mc = 0; e_int[0] = 0;
    chk("R2 local beats ext", mc_src[6:0], 1);
    chk("R4 others see ext", mc_src[13:7], 64);
    clear_all();

    // R7 R6: overflow, hold, clear with a new fault
    next_pc[AW +: AW] = 32'h1111;
    e_dp[1] = 1; tick(); e_dp[1] = 0;
    next_pc[AW +: AW] = 32'h2222;
    e_tmo[1] = 1; tick(); e_tmo[1] = 0;
    chk("R7 overflow set", mc_ovf, 4'b0010);
    chk("R7 cause kept", mc_src[13:7], 8);
    chk("R7 address kept", mc_pc[AW +: AW], 32'h1111);
    repeat (3) tick();
    chk("R6 held until clear", mc_irq, 4'b0010);
    next_pc[AW +: AW] = 32'h3333;
    mc_clr[1] = 1; e_ecc[1] = 1; tick(); mc_clr[1] = 0; e_ecc[1] = 0;
    chk("R6 recapture irq", mc_irq, 4'b0010);
    chk("R6 recapture cause", mc_src[13:7], 16);
    chk("R6 recapture addr", mc_pc[AW +: AW], 32'h3333);
    chk("R6 overflow cleared", mc_ovf, 0);
    clear_all();
    chk("R6 overflow after clear", mc_ovf, 0);

    // R8: recoverable path
    rec_mask = 1; rec_err = 1; tick(); rec_err = 0;
    chk("R8 masked", rec_irq, 0);
    chk("R8 no machine check", mc_irq, 0);
    rec_mask = 0; #1;
    chk("R8 unmasked", rec_irq, 1);
    rec_clr = 1; rec_err = 1; tick(); rec_err = 0;
    chk("R8 set beats clear", rec_irq, 1);
    tick(); rec_clr = 0;
    chk("R8 cleared", rec_irq, 0);

    // R9 R10: fatal path and the two resets
    fatal_info = 32'hDEAD_0001; fatal_err = 1; tick(); fatal_err = 0;
    chk("R9 checkstop", checkstop, 1);
    chk("R9 no machine check", mc_irq, 0);
    chk("R10 resid valid", resid_vld, 1);
    chk("R10 resid data", resid_info, 32'hDEAD_0001);
    fatal_info = 32'hBEEF_0002; fatal_err = 1; tick(); fatal_err = 0;
    chk("R10 frozen vs second fatal", resid_info, 32'hDEAD_0001);
    repeat (2) tick();
    chk("R9 sticky", checkstop, 1);
    rst_n = 0; tick(); rst_n = 1; tick();
    chk("R9 cleared by reset", checkstop, 0);
    chk("R10 survives rst_n", resid_info, 32'hDEAD_0001);
    chk("R10 valid survives rst_n", resid_vld, 1);
    por_n = 0; tick(); por_n = 1; tick();
    chk("R10 por clears valid", resid_vld, 0);
    chk("R10 por clears data", resid_info, 0);
    fatal_info = 32'h0000_C0DE; fatal_err = 1; tick(); fatal_err = 0;
    chk("R10 capture after por", resid_info, 32'h0000_C0DE);

    done = 1;
    summary();
    $finish;
  end
endmodule